// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block works out how many master-clock cycles make up one frame-clock period. The frame clock is the sample-rate clock, with one word per channel in each period. Its rising edges are brought into the master-clock domain through a short synchronizer chain. The span between two successive rising edges is counted, and the count is matched against five oversampling ratios. Three of them (256, 384, 512) belong to the base-rate mode and two (128, 192) to the high-rate mode.

A ratio is reported only after two successive periods have given the same class. With it come the speed-mode flag and a divider value: the ratio divided by 64, which is the master-clock divider for a 64-times-sample-rate serial clock. Counts that match no ratio raise an error flag. After lock, every later period is checked again. A period that gives a different class drops lock and starts detection over. A start pulse clears everything and begins a fresh measurement, for example at the start of an initialization sequence.

The frame clock and master clock are expected to come from one source. No phase relationship between them is assumed.

Top module: `mclk_ratio_detect`

## Requirements
- R1: After reset, locked_o, error_o, ratio_o, high_rate_o and sclk_div_o are all zero.
- R2: A period is the number of clock cycles between two successive synchronized rising edges of lrck_i. The first rising edge after reset or start_i only arms the measurement and produces no classification.
- R3: A period count within plus or minus 2 of a supported ratio is accepted with code 0 = 128, 1 = 192, 2 = 256, 3 = 384, 4 = 512.
- R4: A count outside every window sets error_o and leaves locked_o low. This includes counts that saturate the counter at 1023. error_o clears at the next accepted period.
- R5: locked_o rises only when two consecutive measured periods give the same code. Alternating codes never lock.
- R6: While locked, a period giving another code or no code drops locked_o. That period is discarded, and two further matching periods are needed to lock again.
- R7: While locked, high_rate_o is 1 for codes 0 and 1 and 0 for codes 2 to 4.
- R8: While locked, sclk_div_o is 2, 3, 4, 6 or 8 for codes 0 to 4. While unlocked, ratio_o, high_rate_o and sclk_div_o are zero.
- R9: start_i, sampled on a clock edge, clears locked_o and error_o at that edge and disarms the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrck_i | input | 1 | Frame clock, synchronous to clk_i in frequency |
| start_i | input | 1 | Restart detection, one cycle |
| ratio_o | output | 3 | Detected ratio code |
| high_rate_o | output | 1 | 1 for high-rate mode |
| sclk_div_o | output | 4 | Master-clock divider for a 64x serial clock |
| locked_o | output | 1 | Ratio confirmed |
| error_o | output | 1 | Last period count unsupported |

## Verification
The assertions assume that start_i is synchronous to clk_i. They also assume that lrck_i holds each level for many clock cycles, so each synchronized rising edge is a single event and none is merged with its neighbour. The bench changes lrck_i and start_i only on falling clock edges. Its frames are never shorter than 126 cycles, and it pulses start_i only while lrck_i is low. Because the synchronizer delays every edge by the same amount, the measured period equals the frame length the bench drives.

// File: rtl/mrd_pkg.sv
`timescale 1ns/1ps
package mrd_pkg;
  localparam int NUM_RATIOS = 5;

  typedef enum logic [1:0] {ST_SEEK, ST_CONFIRM, ST_LOCK} det_state_e;

  // ratio = mult * UNIT; code order is the index
  function automatic int ratio_mult(input int idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3:       return 6;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/mrd_edge_sync.sv
`timescale 1ns/1ps
module mrd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], lrck_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/mrd_period_cnt.sv
`timescale 1ns/1ps
module mrd_period_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             rise_i,
  output logic             per_vld_o,
  output logic [CNT_W-1:0] per_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      per_vld_o <= 1'b0;
      per_cnt_o <= '0;
    end else if (clear_i) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      per_vld_o <= 1'b0;
    end else begin
      per_vld_o <= rise_i & armed_q;
      if (rise_i) begin
        per_cnt_o <= cnt_q;
        cnt_q     <= CNT_W'(1);
        armed_q   <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;  // saturates; long periods fall outside every window
      end
    end
  end

  // R2
  vld_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_vld_o |-> $past(armed_q));
endmodule

// File: rtl/mrd_classify.sv
`timescale 1ns/1ps
module mrd_classify #(
  parameter int CNT_W = 10,
  parameter int UNIT  = 64,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ok_o,
  output logic [2:0]       code_o
);
  localparam int N = mrd_pkg::NUM_RATIOS;

  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_win
    localparam logic [CNT_W-1:0] LO = CNT_W'(mrd_pkg::ratio_mult(i) * UNIT - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(mrd_pkg::ratio_mult(i) * UNIT + TOL);
    assign hit[i] = (cnt_i >= LO) && (cnt_i <= HI);
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) code_o = 3'(i);
    end
  end

  assign ok_o = |hit;
endmodule

// File: rtl/mclk_ratio_detect.sv
`timescale 1ns/1ps
module mclk_ratio_detect #(
  parameter int CNT_W       = 10,
  parameter int UNIT        = 64,
  parameter int TOL         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lrck_i,
  input  logic       start_i,
  output logic [2:0] ratio_o,
  output logic       high_rate_o,
  output logic [3:0] sclk_div_o,
  output logic       locked_o,
  output logic       error_o
);
  import mrd_pkg::*;

  logic             rise;
  logic             per_vld;
  logic [CNT_W-1:0] per_cnt;
  logic             cls_ok;
  logic [2:0]       cls_code;

  det_state_e state_q;
  logic [2:0] cand_q;
  logic [2:0] ratio_q;
  logic       err_q;

  mrd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lrck_i (lrck_i),
    .rise_o (rise)
  );

  mrd_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_i),
    .rise_i    (rise),
    .per_vld_o (per_vld),
    .per_cnt_o (per_cnt)
  );

  mrd_classify #(.CNT_W(CNT_W), .UNIT(UNIT), .TOL(TOL)) u_cls (
    .cnt_i  (per_cnt),
    .ok_o   (cls_ok),
    .code_o (cls_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEEK;
      cand_q  <= '0;
      ratio_q <= '0;
      err_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_SEEK;
      cand_q  <= '0;
      ratio_q <= '0;
      err_q   <= 1'b0;
    end else if (per_vld) begin
      err_q <= ~cls_ok;
      case (state_q)
        ST_SEEK: begin
          if (cls_ok) begin
            cand_q  <= cls_code;
            state_q <= ST_CONFIRM;
          end
        end
        ST_CONFIRM: begin
          if (cls_ok && cls_code == cand_q) begin
            ratio_q <= cand_q;
            state_q <= ST_LOCK;
          end else if (cls_ok) begin
            cand_q <= cls_code;
          end else begin
            state_q <= ST_SEEK;
          end
        end
        ST_LOCK: begin
          // mismatching period is discarded, detection restarts from scratch
          if (!(cls_ok && cls_code == ratio_q)) state_q <= ST_SEEK;
        end
        default: state_q <= ST_SEEK;
      endcase
    end
  end

  assign locked_o = (state_q == ST_LOCK);
  assign error_o  = err_q;

  always_comb begin
    ratio_o     = '0;
    high_rate_o = 1'b0;
    sclk_div_o  = '0;
    if (locked_o) begin
      ratio_o     = ratio_q;
      high_rate_o = (ratio_q < 3'd2);
      sclk_div_o  = 4'(ratio_mult(int'(ratio_q)) * UNIT / 64);
    end
  end

  // R4
  lock_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !error_o);

  // R5
  lock_after_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(per_vld));

  // R6
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && per_vld && !start_i && !(cls_ok && cls_code == ratio_q)) |=> !locked_o);

  // R9
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!locked_o && !error_o));

  // R3
  ratio_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (ratio_o <= 3'd4));
endmodule

// File: tb/tb_mclk_ratio_detect.sv
`timescale 1ns/1ps
module tb_mclk_ratio_detect;
  logic       clk;
  logic       rst_n;
  logic       lrck;
  logic       start;
  logic [2:0] ratio;
  logic       high_rate;
  logic [3:0] sclk_div;
  logic       locked;
  logic       error;

  int n_tests = 0;
  int n_fail  = 0;

  mclk_ratio_detect dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .lrck_i      (lrck),
    .start_i     (start),
    .ratio_o     (ratio),
    .high_rate_o (high_rate),
    .sclk_div_o  (sclk_div),
    .locked_o    (locked),
    .error_o     (error)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // n rising edges of lrck, each frame p cycles; ends low p cycles after last rise
  task automatic frames(input int n, input int p);
    for (int k = 0; k < n; k++) begin
      lrck = 1'b1;
      repeat (p / 2) @(negedge clk);
      lrck = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic restart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk(locked, 0, "R1", "locked");
    chk(error, 0, "R1", "error");
    chk(ratio, 0, "R1", "ratio");
    chk(high_rate, 0, "R1", "high_rate");
    chk(sclk_div, 0, "R1", "sclk_div");
  endtask

  task automatic t_ratios();
    int mults[5] = '{2, 3, 4, 6, 8};
    for (int i = 0; i < 5; i++) begin
      restart();
      frames(3, mults[i] * 64);
      chk(locked, 1, "R5", "locked after two equal periods");
      chk(ratio, i, "R3", "ratio code");
      chk(high_rate, (i < 2) ? 1 : 0, "R7", "high_rate");
      chk(sclk_div, mults[i], "R8", "sclk_div");
      chk(error, 0, "R4", "error on legal ratio");
    end
  endtask

  task automatic t_tolerance();
    restart();
    frames(3, 258);
    chk(locked, 1, "R3", "locked at 258");
    chk(ratio, 2, "R3", "code at 258");
    restart();
    frames(3, 126);
    chk(ratio, 0, "R3", "code at 126");
    restart();
    frames(3, 514);
    chk(ratio, 4, "R3", "code at 514");
    restart();
    frames(3, 190);
    chk(ratio, 1, "R3", "code at 190");
  endtask

  task automatic t_reject();
    restart();
    frames(3, 259);
    chk(error, 1, "R4", "error at 259");
    chk(locked, 0, "R4", "locked at 259");
    restart();
    frames(3, 300);
    chk(error, 1, "R4", "error at 300");
    chk(ratio, 0, "R8", "ratio gated while unlocked");
    restart();
    frames(3, 1100);
    chk(error, 1, "R4", "error on saturated count");
    chk(locked, 0, "R4", "locked on saturated count");
    frames(3, 256);
    chk(error, 0, "R4", "error cleared by accepted period");
    chk(locked, 1, "R4", "lock after recovery");
  endtask

  task automatic t_confirm();
    restart();
    frames(2, 256);
    chk(locked, 0, "R2", "one period after arm is not enough");
    frames(1, 256);
    chk(locked, 1, "R2", "second period locks");
    restart();
    frames(1, 256);
    frames(1, 384);
    frames(1, 256);
    frames(1, 384);
    chk(locked, 0, "R5", "alternating codes never lock");
    chk(error, 0, "R5", "alternating codes no error");
  endtask

  task automatic t_drop();
    restart();
    frames(3, 256);
    chk(locked, 1, "R6", "initial lock");
    frames(2, 384);
    chk(locked, 0, "R6", "lock dropped on new code");
    chk(error, 0, "R6", "no error on legal new code");
    chk(sclk_div, 0, "R8", "div gated after drop");
    frames(1, 384);
    chk(locked, 0, "R6", "one matching period after drop");
    frames(1, 384);
    chk(locked, 1, "R6", "relock");
    chk(ratio, 3, "R6", "relock code");
    frames(1, 300);
    frames(1, 256);
    chk(locked, 0, "R6", "lock dropped on bad count");
    chk(error, 1, "R4", "error on drift to bad count");
  endtask

  task automatic t_start();
    restart();
    frames(3, 512);
    chk(locked, 1, "R9", "locked before start");
    restart();
    chk(locked, 0, "R9", "start clears lock");
    frames(3, 300);
    chk(error, 1, "R9", "error before start");
    restart();
    chk(error, 0, "R9", "start clears error");
  endtask

  initial begin
    rst_n = 1'b0;
    lrck  = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ratios();
    t_tolerance();
    t_reject();
    t_confirm();
    t_drop();
    t_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule